// File: doc/BRIEF.md
# Slave DMA Endpoint Handshake Controller

This block paces an external DMA master against a pair of endpoint packet buffers in a USB peripheral. It raises a request line when the active buffer can take data (IN direction, memory to endpoint) or when a received packet is waiting (OUT direction, endpoint to memory). The master answers with an acknowledge once it owns the bus. While both lines are high, every clock moves one 16-bit word, or one byte when the byte-enable input marks an odd final byte.

Bytes are counted against a programmable burst length and against the buffer limit. The request falls when a burst completes, when the buffer fills or drains, when software ends the transfer, or when DMA is turned off. It stays low until the master has released its acknowledge. When an IN buffer fills, or a transfer ends early with data in it, the controller commits the buffer for transmission with a one-cycle validate pulse. When an OUT buffer has been read out, it frees the buffer with a one-cycle clear pulse. In both cases the active index then toggles. The host side reports sent and received packets, and these take the oldest buffer in ping-pong order.

Top module: `dma_ep_handshake`

## Requirements
- R1: After reset `dreq`, `buf_validate` and `buf_clear` are 0, `buf_occ` is 2'b00, `act_buf` is 0 and `fill_bytes` is 0.
- R2: While `dma_clk_en` or `dma_en` is 0, `dreq` stays low from the next cycle on, and `dack` moves no data (`fill_bytes` is unchanged).
- R3: With `dir_in`=1, `dreq` is raised only while the active buffer is empty. With both buffers committed (`buf_occ`=2'b11), `dreq` stays low.
- R4: With `dir_in`=0, `dreq` is raised only while the active buffer holds a received packet. With both buffers empty, `dreq` stays low.
- R5: A transfer happens on each clock where `dreq` and `dack` are both high. Once the transfers of the current burst reach `burst_len` bytes (`burst_len` even), `dreq` falls on the next cycle and rises again only after `dack` has been low.
- R6: A burst that would pass the buffer end stops at that end, and the next buffer starts a fresh burst count. A buffer of N bytes therefore takes ceil(2*ceil(N/2) / `burst_len`) bursts.
- R7: In the IN direction, the transfer that fills the buffer (BUF_BYTES bytes) is followed on the next cycle by a one-cycle `buf_validate`, with `buf_sel` giving the filled buffer. `act_buf` then points to the other buffer.
- R8: In the IN direction, a `dma_term` pulse while the active buffer holds data commits that buffer with `buf_validate`. A `dma_term` pulse while it is empty produces no pulse. A termination also ends the current burst.
- R9: In the OUT direction, once ceil(L/2) transfers have read a packet of length L, a one-cycle `buf_clear` follows, with `buf_sel` giving the drained buffer. The buffer becomes free and `act_buf` toggles.
- R10: `fill_bytes` advances by 2 on each transfer, or by 1 when `odd_byte` is high, and returns to 0 when the buffer is committed or freed.
- R11: `pkt_sent` (IN) frees the oldest committed buffer. `pkt_rx` (OUT) stores `pkt_len` into the oldest free buffer. A `pkt_rx` is ignored while both buffers are occupied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dma_clk_en | input | 1 | DMA clock enable, off after reset by the system |
| dma_en | input | 1 | DMA enable for the selected endpoint |
| dir_in | input | 1 | 1 = IN (memory to endpoint), 0 = OUT |
| burst_len | input | BURST_W | Burst length in bytes |
| dack | input | 1 | Acknowledge from the DMA master |
| odd_byte | input | 1 | Current transfer carries a single byte |
| dma_term | input | 1 | Transfer termination pulse |
| pkt_rx | input | 1 | OUT: a packet has arrived from the host |
| pkt_len | input | CNT_W | OUT: length of the arriving packet in bytes |
| pkt_sent | input | 1 | IN: the host has taken the oldest committed buffer |
| dreq | output | 1 | Request to the DMA master |
| buf_validate | output | 1 | One-cycle commit of an IN buffer |
| buf_clear | output | 1 | One-cycle release of an OUT buffer |
| buf_sel | output | 1 | Buffer named by the validate or clear pulse |
| act_buf | output | 1 | Buffer the DMA side is working on |
| buf_occ | output | 2 | Per-buffer occupancy |
| fill_bytes | output | CNT_W | Bytes moved in the active buffer so far |

## Verification
The embedded properties check on every cycle that a disabled DMA never leaves the request high, that the request only stands while the active buffer suits the direction, and that a completed burst always drops the request. They also check that validate and clear are single, exclusive pulses agreeing with buffer occupancy, and that the byte count stays inside the buffer limit. Only the bench scenarios show that the counts come out right: bursts per buffer under random burst lengths, truncation at the buffer end, partial commit on termination, odd-length packets, and the ping-pong order in which the host side takes and returns buffers.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;
  typedef enum logic [1:0] {
    HS_IDLE    = 2'd0,
    HS_REQ     = 2'd1,
    HS_RELEASE = 2'd2
  } hs_state_e;
endpackage

// File: rtl/dma_byte_counter.sv
module dma_byte_counter #(
  parameter int CNT_W   = 10,
  parameter int BURST_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               xfer,
  input  logic               odd_byte,
  input  logic               term,
  input  logic               dir_in,
  input  logic [BURST_W-1:0] burst_len,
  input  logic [CNT_W-1:0]   limit,
  output logic [CNT_W-1:0]   fill,
  output logic               burst_end_now,
  output logic               buf_end_now,
  output logic               buf_done
);
  logic [CNT_W-1:0]   fill_q, fill_d;
  logic [BURST_W-1:0] bcnt_q, bcnt_d;
  logic [CNT_W:0]     fill_sum;
  logic [BURST_W:0]   burst_sum;
  logic [1:0]         step;
  logic               term_commit;

  always_comb begin
    step          = odd_byte ? 2'd1 : 2'd2;
    fill_sum      = {1'b0, fill_q} + {{(CNT_W-1){1'b0}}, step};
    burst_sum     = {1'b0, bcnt_q} + {{(BURST_W-1){1'b0}}, step};
    buf_end_now   = xfer && (fill_sum >= {1'b0, limit});
    burst_end_now = xfer && (burst_sum >= {1'b0, burst_len});
    term_commit   = term && dir_in && (xfer || (fill_q != '0));
    buf_done      = buf_end_now || term_commit;
  end

  always_comb begin
    fill_d = fill_q;
    bcnt_d = bcnt_q;
    if (buf_done) begin
      fill_d = '0;
      bcnt_d = '0;
    end else if (term) begin
      bcnt_d = '0;
      if (xfer) fill_d = fill_sum[CNT_W-1:0];
    end else if (xfer) begin
      fill_d = fill_sum[CNT_W-1:0];
      bcnt_d = burst_end_now ? '0 : burst_sum[BURST_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q <= '0;
      bcnt_q <= '0;
    end else begin
      fill_q <= fill_d;
      bcnt_q <= bcnt_d;
    end
  end

  assign fill = fill_q;

  // R10
  fill_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q == '0) || (fill_q < limit));
endmodule

// File: rtl/ep_buf_track.sv
module ep_buf_track #(
  parameter int BUF_BYTES = 512,
  parameter int CNT_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_in,
  input  logic             buf_done,
  input  logic             pkt_rx,
  input  logic [CNT_W-1:0] pkt_len,
  input  logic             pkt_sent,
  output logic             act_idx,
  output logic [1:0]       occ,
  output logic [CNT_W-1:0] act_limit,
  output logic             ready,
  output logic             validate,
  output logic             clear,
  output logic             evt_sel
);
  localparam logic [CNT_W-1:0] FULL_LIM = CNT_W'(BUF_BYTES);

  logic [1:0]       occ_q, occ_d;
  logic             act_q, act_d, far_q, far_d;
  logic [CNT_W-1:0] len_q [2];
  logic [CNT_W-1:0] len_in;
  logic             rx_accept, tx_accept;
  logic             val_q, clr_q, sel_q;

  always_comb begin
    len_in    = (pkt_len > FULL_LIM) ? FULL_LIM : pkt_len;
    rx_accept = !dir_in && pkt_rx && !occ_q[far_q] && (pkt_len != '0);
    tx_accept = dir_in && pkt_sent && occ_q[far_q];
    occ_d     = occ_q;
    act_d     = act_q;
    far_d     = far_q;
    if (buf_done) begin
      occ_d[act_q] = dir_in;
      act_d        = ~act_q;
    end
    if (tx_accept) begin
      occ_d[far_q] = 1'b0;
      far_d        = ~far_q;
    end
    if (rx_accept) begin
      occ_d[far_q] = 1'b1;
      far_d        = ~far_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q <= '0;
      act_q <= 1'b0;
      far_q <= 1'b0;
      val_q <= 1'b0;
      clr_q <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      occ_q <= occ_d;
      act_q <= act_d;
      far_q <= far_d;
      val_q <= buf_done && dir_in;
      clr_q <= buf_done && !dir_in;
      if (buf_done) sel_q <= act_q;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_len
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        len_q[g] <= '0;
      end else if (rx_accept && (far_q == 1'(g))) begin
        len_q[g] <= len_in;
      end
    end
  end

  always_comb begin
    act_limit = dir_in ? FULL_LIM : len_q[act_q];
    ready     = dir_in ? !occ_q[act_q] : occ_q[act_q];
  end

  assign act_idx  = act_q;
  assign occ      = occ_q;
  assign validate = val_q;
  assign clear    = clr_q;
  assign evt_sel  = sel_q;

  // R7
  validate_marks_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    val_q |-> occ_q[sel_q]);
  // R9
  clear_marks_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |-> !occ_q[sel_q]);
  // R7
  commit_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (val_q || clr_q) |=> !(val_q || clr_q));
endmodule

// File: rtl/dma_req_fsm.sv
module dma_req_fsm
  import dma_hs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ready,
  input  logic dack,
  input  logic term,
  input  logic burst_end_now,
  input  logic buf_end_now,
  output logic dreq,
  output logic xfer
);
  hs_state_e state_q, state_d;

  always_comb begin
    xfer    = run && (state_q == HS_REQ) && dack;
    state_d = state_q;
    unique case (state_q)
      HS_IDLE: begin
        if (run && ready && !term) state_d = HS_REQ;
      end
      HS_REQ: begin
        if (!run || !ready || term || burst_end_now || buf_end_now)
          state_d = HS_RELEASE;
      end
      HS_RELEASE: begin
        if (!dack) state_d = HS_IDLE;
      end
      default: state_d = HS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_IDLE;
    else        state_q <= state_d;
  end

  assign dreq = (state_q == HS_REQ);

  // R2
  dreq_off_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !dreq);
  // R5
  burst_end_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && burst_end_now) |=> !dreq);
  // R5
  rerequest_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == HS_RELEASE && dack) |=> !dreq);
endmodule

// File: rtl/dma_ep_handshake.sv
module dma_ep_handshake #(
  parameter int BUF_BYTES = 512,
  parameter int BURST_W   = 10,
  localparam int CNT_W    = $clog2(BUF_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dma_clk_en,
  input  logic               dma_en,
  input  logic               dir_in,
  input  logic [BURST_W-1:0] burst_len,
  input  logic               dack,
  input  logic               odd_byte,
  input  logic               dma_term,
  input  logic               pkt_rx,
  input  logic [CNT_W-1:0]   pkt_len,
  input  logic               pkt_sent,
  output logic               dreq,
  output logic               buf_validate,
  output logic               buf_clear,
  output logic               buf_sel,
  output logic               act_buf,
  output logic [1:0]         buf_occ,
  output logic [CNT_W-1:0]   fill_bytes
);
  logic             run, ready, xfer;
  logic             burst_end_now, buf_end_now, buf_done;
  logic [CNT_W-1:0] act_limit;

  assign run = dma_clk_en && dma_en;

  dma_req_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .run           (run),
    .ready         (ready),
    .dack          (dack),
    .term          (dma_term),
    .burst_end_now (burst_end_now),
    .buf_end_now   (buf_end_now),
    .dreq          (dreq),
    .xfer          (xfer)
  );

  dma_byte_counter #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_n),
    .xfer          (xfer),
    .odd_byte      (odd_byte),
    .term          (dma_term),
    .dir_in        (dir_in),
    .burst_len     (burst_len),
    .limit         (act_limit),
    .fill          (fill_bytes),
    .burst_end_now (burst_end_now),
    .buf_end_now   (buf_end_now),
    .buf_done      (buf_done)
  );

  ep_buf_track #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_bufs (
    .clk       (clk),
    .rst_n     (rst_n),
    .dir_in    (dir_in),
    .buf_done  (buf_done),
    .pkt_rx    (pkt_rx),
    .pkt_len   (pkt_len),
    .pkt_sent  (pkt_sent),
    .act_idx   (act_buf),
    .occ       (buf_occ),
    .act_limit (act_limit),
    .ready     (ready),
    .validate  (buf_validate),
    .clear     (buf_clear),
    .evt_sel   (buf_sel)
  );

  // R3
  req_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> ready);
  // R7
  commit_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_validate && buf_clear));
  // R2
  no_move_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !dma_term) |=> $stable(fill_bytes));
endmodule

// File: tb/dma_ep_handshake_tb_top.sv
module dma_ep_handshake_tb_top;
  localparam int BUF = 64;
  localparam int BW  = 10;
  localparam int CW  = $clog2(BUF + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic dma_clk_en, dma_en, dir_in, dack, odd_byte, dma_term, pkt_rx, pkt_sent;
  logic [BW-1:0] burst_len;
  logic [CW-1:0] pkt_len;
  logic dreq, buf_validate, buf_clear, buf_sel, act_buf;
  logic [1:0] buf_occ;
  logic [CW-1:0] fill_bytes;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int exp_act = 0;

  always #2 clk = ~clk;

  dma_ep_handshake #(.BUF_BYTES(BUF), .BURST_W(BW)) dut_i (
    .clk(clk), .rst_n(rst_n), .dma_clk_en(dma_clk_en), .dma_en(dma_en),
    .dir_in(dir_in), .burst_len(burst_len), .dack(dack), .odd_byte(odd_byte),
    .dma_term(dma_term), .pkt_rx(pkt_rx), .pkt_len(pkt_len), .pkt_sent(pkt_sent),
    .dreq(dreq), .buf_validate(buf_validate), .buf_clear(buf_clear),
    .buf_sel(buf_sel), .act_buf(act_buf), .buf_occ(buf_occ), .fill_bytes(fill_bytes)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      report();
      $finish;
    end
  end

  function automatic int exp_bursts(input int bytes, input int b);
    int moved = ((bytes + 1) / 2) * 2;
    return (moved + b - 1) / b;
  endfunction

  task automatic host_sent();
    @(negedge clk); pkt_sent = 1'b1;
    @(negedge clk); pkt_sent = 1'b0;
  endtask

  task automatic host_rx(input int len);
    @(negedge clk); pkt_rx = 1'b1; pkt_len = CW'(len);
    @(negedge clk); pkt_rx = 1'b0;
  endtask

  task automatic quiet_check(input int n, input string req);
    int seen = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (dreq) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic run_buf(input int b, input bit want_in,
                         output int beats, output int bursts, output int sel, output bit ok);
    int dly = $urandom % 3;
    burst_len = BW'(b);
    beats = 0; bursts = 0; sel = -1; ok = 1'b0;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      if (want_in ? buf_validate : buf_clear) begin
        ok = 1'b1; sel = int'(buf_sel); dack = 1'b0;
        break;
      end
      if (!dreq) begin
        if (dack) dly = $urandom % 3;
        dack = 1'b0;
      end else if (!dack) begin
        if (dly == 0) begin dack = 1'b1; bursts++; end
        else dly--;
      end
      if (dreq && dack) beats++;
    end
  endtask

  initial begin
    int beats, bursts, sel, b;
    bit ok;
    void'($urandom(32'd1234));
    rst_n = 1'b0; dma_clk_en = 1'b0; dma_en = 1'b0; dir_in = 1'b1; dack = 1'b0;
    odd_byte = 1'b0; dma_term = 1'b0; pkt_rx = 1'b0; pkt_sent = 1'b0;
    burst_len = '0; pkt_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!dreq && !buf_validate && !buf_clear, "R1 outputs", {dreq, buf_validate, buf_clear}, 0);
    chk(buf_occ == 2'b00 && act_buf == 1'b0, "R1 buffers", {buf_occ, act_buf}, 0);
    chk(fill_bytes == 0, "R1 fill", fill_bytes, 0);

    // R2: clock enable off, master pushing acknowledge
    dma_en = 1'b1; dack = 1'b1; burst_len = 10'd200;
    quiet_check(12, "R2 no dreq while clock off");
    chk(fill_bytes == 0, "R2 no data moved", fill_bytes, 0);
    dack = 1'b0;
    @(negedge clk);
    dma_clk_en = 1'b1;

    // R10 / R8: partial buffer with an odd byte, then termination
    for (int n = 0; n < 50 && !dreq; n++) @(negedge clk);
    dack = 1'b1;
    repeat (3) @(negedge clk);
    chk(fill_bytes == 6, "R10 word counting", fill_bytes, 6);
    odd_byte = 1'b1;
    @(negedge clk);
    chk(fill_bytes == 7, "R10 odd byte", fill_bytes, 7);
    odd_byte = 1'b0; dack = 1'b0; dma_term = 1'b1;
    @(negedge clk);
    dma_term = 1'b0;
    chk(buf_validate == 1'b1, "R8 partial validate", buf_validate, 1);
    chk(int'(buf_sel) == exp_act, "R8 validate select", buf_sel, exp_act);
    chk(fill_bytes == 0, "R10 fill reset on commit", fill_bytes, 0);
    exp_act ^= 1;
    chk(int'(act_buf) == exp_act, "R7 active toggles", act_buf, exp_act);
    // R8: termination on an empty buffer
    repeat (4) @(negedge clk);
    dma_term = 1'b1;
    @(negedge clk);
    dma_term = 1'b0;
    chk(buf_validate == 1'b0, "R8 empty term no validate", buf_validate, 0);
    chk(buf_occ == 2'b01, "R8 occupancy", buf_occ, 1);
    host_sent();
    @(negedge clk);
    chk(buf_occ == 2'b00, "R11 sent frees buffer", buf_occ, 0);

    // R5 R6 R7 R3: IN fills with directed and random burst lengths
    for (int i = 0; i < 7; i++) begin
      b = (i < 2) ? 48 : (i == 2) ? 2 : 2 * (1 + ($urandom % 40));
      run_buf(b, 1'b1, beats, bursts, sel, ok);
      chk(ok, "R7 validate seen", ok, 1);
      chk(beats == BUF / 2, "R7 beats per full buffer", beats, BUF / 2);
      chk(bursts == exp_bursts(BUF, b), "R6 bursts per buffer", bursts, exp_bursts(BUF, b));
      chk(sel == exp_act, "R7 validate select", sel, exp_act);
      exp_act ^= 1;
      if (i >= 1) begin
        @(negedge clk);
        chk(buf_occ == 2'b11, "R3 both committed", buf_occ, 3);
        quiet_check(8, "R3 no dreq when full");
        host_sent();
        @(negedge clk);
        chk($countones(buf_occ) == 1, "R11 one freed", buf_occ, 1);
      end
    end
    host_sent();
    @(negedge clk);
    chk(buf_occ == 2'b00, "R11 all freed", buf_occ, 0);

    // switch to OUT
    dma_en = 1'b0;
    quiet_check(4, "R2 dreq off when disabled");
    dir_in = 1'b0;
    @(negedge clk);
    dma_en = 1'b1;
    quiet_check(8, "R4 no dreq when empty");

    host_rx(20);
    run_buf(8, 1'b0, beats, bursts, sel, ok);
    chk(ok, "R9 clear seen", ok, 1);
    chk(beats == 10, "R9 beats", beats, 10);
    chk(bursts == exp_bursts(20, 8), "R5 bursts", bursts, exp_bursts(20, 8));
    chk(sel == exp_act, "R9 clear select", sel, exp_act);
    exp_act ^= 1;

    host_rx(13);
    host_rx(30);
    host_rx(40);
    @(negedge clk);
    chk(buf_occ == 2'b11, "R11 both received", buf_occ, 3);
    run_buf(64, 1'b0, beats, bursts, sel, ok);
    chk(ok && beats == 7, "R9 odd length beats", beats, 7);
    chk(sel == exp_act, "R9 clear select odd", sel, exp_act);
    exp_act ^= 1;
    run_buf(10, 1'b0, beats, bursts, sel, ok);
    chk(ok && beats == 15, "R9 second packet beats", beats, 15);
    chk(bursts == exp_bursts(30, 10), "R5 bursts second", bursts, exp_bursts(30, 10));
    chk(sel == exp_act, "R9 ping-pong order", sel, exp_act);
    @(negedge clk);
    chk(buf_occ == 2'b00, "R11 third rx ignored", buf_occ, 0);
    quiet_check(8, "R4 no dreq after drain");

    report();
    $finish;
  end
endmodule